// File: doc/BRIEF.md
# Free-Running and Cyclic Timer Counter

This block is the counting core of one timer channel. A prescaled tick input sets the count rate. While the run bit is set, every tick raises the counter by one. Clearing the run bit freezes the count where it stands. In free-running operation the counter passes all-ones and wraps to zero, and that wrap raises a sticky overflow flag. In cyclic operation the counter is compared with a period register. When the count equals the period on a tick, the block raises a sticky match flag and returns the counter to its restart value instead of incrementing it.

Software controls the block through a small write port with five registers:

| Address | Register |
|---|---|
| 0 | control: bit 0 run, bit 1 waveform mode, bit 2 clear-on-match |
| 1 | count load |
| 2 | period |
| 3 | status: bit 0 overflow, bit 1 match |
| 4 | interrupt enable: bit 0 overflow, bit 1 match |

A parameter selects the variant. The base variant restarts at zero and is cyclic only when mode bits ask for it. The alternate variant restarts at one and is always cyclic. A registered interrupt request combines the flags with their enables.

Top module: `cyc_timer`

## Requirements
- R1: After reset the count is 0, both flags and the interrupt request are 0, the run bit and both enables are 0, and the period is all-ones.
- R2: On a clock edge where the run bit (control bit 0) is 1 and `tick_i` is 1, the count rises by one. Without both of these, and without a count load, the count holds.
- R3: Writing the control register with bit 0 = 0 stops counting and keeps the current count. Setting the bit again resumes from that value.
- R4: A counting step from all-ones to zero sets the overflow flag (status bit 0). This applies only when that step is not a period match.
- R5: In the base variant, cyclic operation is active when control bit 1 is 1, or when control bit 1 is 0 and control bit 2 is 1. With both bits 0, the counter runs past the period value.
- R6: In cyclic operation, a step taken while the count equals the period sets the match flag (status bit 1) and loads the restart value. The base variant restarts at 0, so a period of N gives a cycle of N+1 ticks.
- R7: The alternate variant (`CLR_ONE`=1) is cyclic whatever the control bits hold, and it restarts at 1, so a period of N gives N ticks.
- R8: Flags stay set until software clears them. Writing status with a bit at 0 clears that flag, and writing a 1 leaves it unchanged. If a set event and a clear fall in the same cycle, the flag stays set.
- R9: A write to address 1 loads the count directly. It overrides any step in that cycle and raises no flag.
- R10: One cycle after the flags are seen, `irq_o` equals (overflow AND enable bit 0) OR (match AND enable bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Prescaled count enable, one cycle per count step |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0 control, 1 count, 2 period, 3 status, 4 enable) |
| wr_data_i | input | CNT_W | Write data |
| count_o | output | CNT_W | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 1 | Sticky period-match flag |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The properties assume that `tick_i` and the write port only change between clock edges. They also assume that writes go to the five defined addresses, so an unlisted address never stands in for a load or a status clear. The stimulus drives every input at the falling edge and uses only the listed addresses. It places count loads next to the wrap and match points, so that each flag event arises from a genuine step. Both variants receive the same stimulus, side by side.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PER  = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd4;
  localparam int FLG_N  = 2;
  localparam int F_OVF  = 0;
  localparam int F_CMP  = 1;
  localparam int C_RUN  = 0;
  localparam int C_WAVE = 1;
  localparam int C_COC  = 2;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sh_q[STAGES-1];
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter bit CLR_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              run,
  output logic              cyclic,
  output logic [CNT_W-1:0]  period,
  output logic [FLG_N-1:0]  ien
);
  logic             run_q, run_d, wave_q, wave_d, coc_q, coc_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [FLG_N-1:0] ien_q, ien_d;
  logic             ctrl_we, per_we, ien_we;

  assign ctrl_we = wr_en && (wr_addr == A_CTRL);
  assign per_we  = wr_en && (wr_addr == A_PER);
  assign ien_we  = wr_en && (wr_addr == A_IEN);

  always_comb begin
    run_d  = run_q;
    wave_d = wave_q;
    coc_d  = coc_q;
    per_d  = per_q;
    ien_d  = ien_q;
    if (ctrl_we) begin
      run_d  = wr_data[C_RUN];
      wave_d = wr_data[C_WAVE];
      coc_d  = wr_data[C_COC];
    end
    if (per_we) per_d = wr_data;
    if (ien_we) ien_d = wr_data[FLG_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      wave_q <= 1'b0;
      coc_q  <= 1'b0;
      per_q  <= '1;
      ien_q  <= '0;
    end else begin
      run_q  <= run_d;
      wave_q <= wave_d;
      coc_q  <= coc_d;
      per_q  <= per_d;
      ien_q  <= ien_d;
    end
  end

  generate
    if (CLR_ONE) begin : g_always_cyc
      assign cyclic = 1'b1;
    end else begin : g_mode_cyc
      assign cyclic = wave_q | (~wave_q & coc_q);
    end
  endgenerate

  assign run    = run_q;
  assign period = per_q;
  assign ien    = ien_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W   = 16,
  parameter bit CLR_ONE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             cyclic,
  input  logic [CNT_W-1:0] period,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt,
  output logic             cmp_evt
);
  localparam logic [CNT_W-1:0] RESTART = CLR_ONE ? CNT_W'(1) : '0;
  localparam logic [CNT_W-1:0] TOP     = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step, hit;

  assign step = run & tick & ~ld_en;
  assign hit  = cyclic & (cnt_q == period);

  always_comb begin
    cnt_d = cnt_q;
    if (ld_en)     cnt_d = ld_val;
    else if (step) cnt_d = hit ? RESTART : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ovf_evt = step & ~hit & (cnt_q == TOP);
  assign cmp_evt = step & hit;
  assign count   = cnt_q;
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_req,
  input  logic [N-1:0] ien,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flg_q, flg_d;
  logic         irq_q, irq_d;

  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_comb flg_d[i] = set_evt[i] | (flg_q[i] & ~clr_req[i]);
    end
  endgenerate

  assign irq_d = |(flg_q & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      irq_q <= 1'b0;
    end else begin
      flg_q <= flg_d;
      irq_q <= irq_d;
    end
  end

  assign flags = flg_q;
  assign irq   = irq_q;
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter bit CLR_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_flag_o,
  output logic              cmp_flag_o,
  output logic              irq_o
);
  logic             rst_n_s;
  logic             run, cyclic, ld_en, stat_we, ovf_evt, cmp_evt;
  logic [CNT_W-1:0] period;
  logic [FLG_N-1:0] ien, evts, clr_req, flags;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  tmr_regs #(.CNT_W(CNT_W), .CLR_ONE(CLR_ONE)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .run(run), .cyclic(cyclic), .period(period), .ien(ien)
  );

  assign ld_en   = wr_en_i && (wr_addr_i == A_CNT);
  assign stat_we = wr_en_i && (wr_addr_i == A_STAT);

  tmr_counter #(.CNT_W(CNT_W), .CLR_ONE(CLR_ONE)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .run(run), .tick(tick_i), .cyclic(cyclic),
    .period(period), .ld_en(ld_en), .ld_val(wr_data_i), .count(count_o),
    .ovf_evt(ovf_evt), .cmp_evt(cmp_evt)
  );

  always_comb begin
    evts           = '0;
    evts[F_OVF]    = ovf_evt;
    evts[F_CMP]    = cmp_evt;
    clr_req        = {FLG_N{stat_we}} & ~wr_data_i[FLG_N-1:0];
  end

  tmr_flags #(.N(FLG_N)) u_flags (
    .clk(clk), .rst_n(rst_n_s), .set_evt(evts), .clr_req(clr_req),
    .ien(ien), .flags(flags), .irq(irq_o)
  );

  assign ovf_flag_o = flags[F_OVF];
  assign cmp_flag_o = flags[F_CMP];
endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter bit CLR_ONE = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [CNT_W-1:0]  wr_data_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              ovf_flag_o,
  input logic              cmp_flag_o,
  input logic              irq_o
);
  localparam logic [CNT_W-1:0] RESTART = CLR_ONE ? CNT_W'(1) : '0;

  // R9
  load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_CNT) |=> (count_o == $past(wr_data_i)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !(wr_en_i && wr_addr_i == A_CNT)) |=> $stable(count_o));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_o && !(wr_en_i && wr_addr_i == A_STAT && !wr_data_i[F_OVF])) |=> ovf_flag_o);

  // R8
  cmp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag_o && !(wr_en_i && wr_addr_i == A_STAT && !wr_data_i[F_CMP])) |=> cmp_flag_o);

  // R4
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag_o) |-> ($past(count_o) == '1 && count_o == '0));

  // R6
  match_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag_o) |-> (count_o == RESTART));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(ovf_flag_o || cmp_flag_o));
endmodule

bind cyc_timer cyc_timer_chk #(.CNT_W(CNT_W), .CLR_ONE(CLR_ONE)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .count_o(count_o),
  .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o), .irq_o(irq_o)
);

// File: tb/cyc_timer_bench.sv
module cyc_timer_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         we = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] data = '0;
  logic [W-1:0] cnt0, cnt1;
  logic         ovf0, ovf1, cmp0, cmp1, irq0, irq1;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  cyc_timer #(.CNT_W(W), .CLR_ONE(1'b0)) u_cyc_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(we), .wr_addr_i(addr),
    .wr_data_i(data), .count_o(cnt0), .ovf_flag_o(ovf0), .cmp_flag_o(cmp0), .irq_o(irq0)
  );

  cyc_timer #(.CNT_W(W), .CLR_ONE(1'b1)) u_cyc_timer_alt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(we), .wr_addr_i(addr),
    .wr_data_i(data), .count_o(cnt1), .ovf_flag_o(ovf1), .cmp_flag_o(cmp1), .irq_o(irq1)
  );

  typedef struct {
    logic [W-1:0] c [2];
    logic         o [2];
    logic         m [2];
    logic         i [2];
    string        tag;
  } exp_t;

  exp_t q[$];

  // reference state, one slot per variant (slot 1 restarts at one, always cyclic)
  logic [W-1:0] r_cnt [2];
  logic [W-1:0] r_per [2];
  logic         r_run [2], r_wave [2], r_coc [2], r_ovf [2], r_cmp [2], r_irq [2];
  logic [1:0]   r_ien [2];

  task automatic model_init();
    for (int k = 0; k < 2; k++) begin
      r_cnt[k] = '0; r_per[k] = '1; r_run[k] = 0; r_wave[k] = 0; r_coc[k] = 0;
      r_ovf[k] = 0; r_cmp[k] = 0; r_irq[k] = 0; r_ien[k] = '0;
    end
  endtask

  task automatic model_step(input bit tk, input bit w, input logic [2:0] a, input logic [W-1:0] d);
    for (int k = 0; k < 2; k++) begin
      bit cyc, load, stp, match, oe, ce, sw;
      logic [W-1:0] nc;
      cyc   = (k == 1) ? 1'b1 : (r_wave[k] || r_coc[k]);
      load  = w && a == 3'd1;
      stp   = r_run[k] && tk && !load;
      match = cyc && r_cnt[k] == r_per[k];
      nc    = load ? d : (stp ? (match ? W'(k) : r_cnt[k] + W'(1)) : r_cnt[k]);
      oe    = stp && !match && r_cnt[k] == '1;
      ce    = stp && match;
      sw    = w && a == 3'd3;
      r_irq[k] = (r_ovf[k] && r_ien[k][0]) || (r_cmp[k] && r_ien[k][1]);
      r_ovf[k] = oe || (r_ovf[k] && !(sw && !d[0]));
      r_cmp[k] = ce || (r_cmp[k] && !(sw && !d[1]));
      r_cnt[k] = nc;
      if (w && a == 3'd0) begin r_run[k] = d[0]; r_wave[k] = d[1]; r_coc[k] = d[2]; end
      if (w && a == 3'd2) r_per[k] = d;
      if (w && a == 3'd4) r_ien[k] = d[1:0];
    end
  endtask

  // driver: one clock cycle of stimulus, expected outcome pushed to scoreboard
  task automatic cyc(input bit tk, input bit w, input logic [2:0] a, input logic [W-1:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    tick = tk; we = w; addr = a; data = d;
    model_step(tk, w, a, d);
    for (int k = 0; k < 2; k++) begin
      e.c[k] = r_cnt[k]; e.o[k] = r_ovf[k]; e.m[k] = r_cmp[k]; e.i[k] = r_irq[k];
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int j = 0; j < n; j++) cyc(0, 0, 3'd0, '0, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int j = 0; j < n; j++) cyc(1, 0, 3'd0, '0, tag);
  endtask

  // monitor: compares both variants after each rising edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic [W-1:0] gc [2];
      logic         go [2], gm [2], gi [2];
      e = q.pop_front();
      gc[0] = cnt0; go[0] = ovf0; gm[0] = cmp0; gi[0] = irq0;
      gc[1] = cnt1; go[1] = ovf1; gm[1] = cmp1; gi[1] = irq1;
      for (int k = 0; k < 2; k++) begin
        n_cmp++;
        if (gc[k] !== e.c[k] || go[k] !== e.o[k] || gm[k] !== e.m[k] || gi[k] !== e.i[k]) begin
          n_bad++;
          $display("FAIL %s variant%0d: got cnt=%h ovf=%b cmp=%b irq=%b exp cnt=%h ovf=%b cmp=%b irq=%b",
                   e.tag, k, gc[k], go[k], gm[k], gi[k], e.c[k], e.o[k], e.m[k], e.i[k]);
        end
      end
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    n_cmp++;
    if (cnt0 !== '0 || ovf0 || cmp0 || irq0 || cnt1 !== '0 || ovf1 || cmp1 || irq1) begin
      n_bad++;
      $display("FAIL R1: got cnt=%h/%h flags=%b%b%b%b irq=%b%b exp zeros", cnt0, cnt1, ovf0, cmp0, ovf1, cmp1, irq0, irq1);
    end
    // R2: ticks while stopped do nothing (alt variant: period all-ones, no match yet)
    ticks(3, "R2 stopped");
    cyc(0, 1, 3'd0, W'(1), "R2 run");
    cyc(1, 0, 3'd0, '0, "R2 step");
    cyc(0, 0, 3'd0, '0, "R2 no tick");
    ticks(3, "R2 steps");
    // R3: stop keeps count, restart resumes
    cyc(1, 1, 3'd0, W'(0), "R3 stop");
    ticks(4, "R3 held");
    cyc(0, 1, 3'd0, W'(1), "R3 resume");
    ticks(2, "R3 resumed");
    // R9: load wins over a step in the same cycle
    cyc(1, 1, 3'd1, 16'hFFFD, "R9 load");
    // R4 wrap (alt variant matches all-ones and restarts at 1: R7)
    ticks(4, "R4 wrap R7");
    // R10 irq from overflow enable
    cyc(0, 1, 3'd4, W'(1), "R10 ovf en");
    idle(2, "R10 irq");
    // R8 clear overflow by writing 0, leave match with 1
    cyc(0, 1, 3'd3, W'(2), "R8 clear ovf");
    idle(2, "R8 cleared");
    cyc(0, 1, 3'd3, W'(0), "R8 clear all");
    // R8 set wins over clear
    cyc(0, 1, 3'd1, 16'hFFFF, "R8 preload");
    cyc(1, 1, 3'd3, W'(0), "R8 set wins");
    idle(2, "R8 kept");
    cyc(0, 1, 3'd3, W'(0), "R8 clear");
    cyc(0, 1, 3'd4, W'(0), "R10 disable");
    // R6 / R5 cyclic via waveform-mode bit
    cyc(0, 1, 3'd2, W'(3), "R6 period");
    cyc(0, 1, 3'd1, W'(0), "R6 zero");
    cyc(0, 1, 3'd0, W'(3), "R5 wave bit");
    ticks(9, "R6 cycle");
    cyc(0, 1, 3'd4, W'(2), "R10 cmp en");
    idle(2, "R10 cmp irq");
    cyc(0, 1, 3'd3, W'(1), "R8 clear cmp");
    // R5 via clear-on-match bit
    cyc(0, 1, 3'd0, W'(5), "R5 coc bit");
    ticks(6, "R5 coc cycle");
    // R5 free-running passes the period (alt variant still cyclic: R7)
    cyc(0, 1, 3'd1, W'(0), "R5 zero");
    cyc(0, 1, 3'd0, W'(1), "R5 free");
    ticks(7, "R5 free R7");
    idle(2, "end");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule